// File: doc/BRIEF.md
# Target Bus Phase Sequencer

This block is the target side of a parallel peripheral bus. While the bus is idle it watches the select line, the data lines and the busy and I/O lines. Once it decides that an initiator has selected it, it takes busy and then steps the bus through a fixed order of phases: command, an optional data phase, status, and a single message byte. After the message it releases busy, and the bus returns to the free state. The sequencer drives the three phase lines (control/data, I/O and message) itself. It works out how long the command is from the group field in the top three bits of the first command byte.

Every byte moves through an internal request/acknowledge engine. The sequencer starts that engine and waits for it to finish. On the upstream side there is no handshake. Each command byte appears on a byte output with a one-cycle strobe. The transfer length, the direction, the status byte and the message byte are level inputs, and they are sampled when the last command byte completes. Data-in bytes are read from an input selected by a byte-index output. Data-out bytes leave on a byte output with a strobe.

Top module: `tgt_phase_seq`

## Requirements
- R1: Selection is accepted only when all of the following hold together for SETTLE_CYC consecutive clock edges: select is high, data bit MY_ID is high, external busy is low and the bus I/O line is low. If any of them is false for a single cycle, the count restarts. `bsy_o` rises on the edge after the SETTLE_CYC-th qualifying edge.
- R2: Once busy is asserted, the command phase begins after select is released. While the command phase lasts, the phase lines {msg_o,cd_o,io_o} read 3'b010.
- R3: The group field is bits [7:5] of command byte 0. Group 0 means 6 command bytes, groups 1 and 2 mean 10, and group 5 means 12. Each received byte is presented on `cmd_byte_o` together with a one-cycle `cmd_stb_o`.
- R4: Any other group ends the command after byte 0. The data phase is skipped, and the status byte is 8'h02.
- R5: A data-in phase shows phase lines 3'b001. It sends `job_len_i` bytes, and byte k is taken from `data_tx_i` while `xfer_idx_o` equals k.
- R6: A data-out phase shows phase lines 3'b000. Each of the `job_len_i` bytes received appears on `data_rx_o` with a one-cycle `data_rx_stb_o`, in order.
- R7: A zero `job_len_i` means there is no data phase, and status follows the command directly.
- R8: The status phase shows phase lines 3'b011 and transfers exactly one byte. That byte equals `job_status_i`, sampled when the command ends.
- R9: The message phase shows phase lines 3'b111 and transfers exactly one byte, `msg_byte_i`. After it, `bsy_o` falls and all phase lines are low.
- R10: For bytes the target sends, the data is driven SETUP_CYC cycles before `req_o` rises. `req_o` stays high until `ack_i` is seen. No new request appears while `ack_i` is still high.
- R11: `db_oe_o` is high only while `io_o` is high. `req_o` is high only while `bsy_o` is high.
- R12: The phase lines do not change while `req_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Bus select line |
| bsy_i | input | 1 | Busy driven by other devices |
| bus_io_i | input | 1 | Bus I/O line as observed |
| ack_i | input | 1 | Initiator acknowledge |
| db_i | input | DB_W | Bus data lines as observed |
| bsy_o | output | 1 | Target busy |
| cd_o | output | 1 | Control/data phase line |
| io_o | output | 1 | I/O phase line |
| msg_o | output | 1 | Message phase line |
| req_o | output | 1 | Target request |
| db_o | output | DB_W | Data driven by the target |
| db_oe_o | output | 1 | Data drive enable |
| cmd_byte_o | output | 8 | Received command byte |
| cmd_stb_o | output | 1 | Command byte strobe |
| job_len_i | input | LEN_W | Data phase length in bytes |
| job_din_i | input | 1 | 1 = data flows to the initiator |
| job_status_i | input | 8 | Status byte to send |
| msg_byte_i | input | 8 | Message byte to send |
| xfer_idx_o | output | LEN_W | Byte index within the current phase |
| data_tx_i | input | 8 | Data-in byte for the current index |
| data_rx_o | output | 8 | Received data-out byte |
| data_rx_stb_o | output | 1 | Data-out byte strobe |

## Verification
The bench builds the block with MY_ID=5, SETTLE_CYC=3, SETUP_CYC=2 and LEN_W=6. The short settle window makes it cheap to interrupt qualification on the last possible cycle and confirm that the count restarts. The two-cycle setup allows the data-before-request rule to be seen one sample ahead. The six-bit length lets one directed session run to the largest transfer, 63 bytes. Random sessions choose among the four supported groups and four unsupported ones, lengths from 0 to 20, both directions, and random status and message bytes.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [2:0] {
    PH_FREE = 3'd0,
    PH_SELD = 3'd1,
    PH_CMD  = 3'd2,
    PH_DIN  = 3'd3,
    PH_DOUT = 3'd4,
    PH_STAT = 3'd5,
    PH_MSG  = 3'd6
  } phase_e;

  localparam logic [7:0] STATUS_CHECK = 8'h02;

  // command length from the group field; zero marks an unsupported group
  function automatic logic [3:0] cdb_len(input logic [2:0] grp);
    case (grp)
      3'd0:       return 4'd6;
      3'd1, 3'd2: return 4'd10;
      3'd5:       return 4'd12;
      default:    return 4'd0;
    endcase
  endfunction

  // {msg, cd, io}
  function automatic logic [2:0] phase_lines(input phase_e ph);
    case (ph)
      PH_CMD:  return 3'b010;
      PH_DIN:  return 3'b001;
      PH_STAT: return 3'b011;
      PH_MSG:  return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic target_sends(input phase_e ph);
    return (ph == PH_DIN) || (ph == PH_STAT) || (ph == PH_MSG);
  endfunction

  function automatic logic moves_bytes(input phase_e ph);
    return (ph == PH_CMD) || (ph == PH_DIN) || (ph == PH_DOUT) ||
           (ph == PH_STAT) || (ph == PH_MSG);
  endfunction

endpackage

// File: rtl/tps_sel_qual.sv
module tps_sel_qual #(
  parameter int DB_W       = 8,
  parameter int MY_ID      = 3,
  parameter int SETTLE_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_i,
  input  logic            bsy_i,
  input  logic            bus_io_i,
  input  logic [DB_W-1:0] db_i,
  output logic            sel_ok_o
);

  logic cond;
  assign cond = sel_i & db_i[MY_ID] & ~bsy_i & ~bus_io_i;

  generate
    if (SETTLE_CYC == 0) begin : g_direct
      assign sel_ok_o = cond;
    end else begin : g_count
      localparam int CNT_W = $clog2(SETTLE_CYC + 1);
      localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SETTLE_CYC);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!cond)        cnt_q <= '0;
        else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
      end

      assign sel_ok_o = cond && (cnt_q == CNT_TOP);

      // qualification only after a qualifying edge
      assert_qual_follows_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ok_o |-> $past(cond));
    end
  endgenerate

endmodule

// File: rtl/tps_handshake.sv
module tps_handshake #(
  parameter int DB_W      = 8,
  parameter int SETUP_CYC = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            out_i,
  input  logic [DB_W-1:0] byte_i,
  input  logic            ack_i,
  input  logic [DB_W-1:0] db_i,
  output logic            req_o,
  output logic [DB_W-1:0] db_o,
  output logic            db_oe_o,
  output logic [DB_W-1:0] byte_o,
  output logic            done_o,
  output logic            idle_o
);

  typedef enum logic [1:0] {HS_IDLE, HS_SETUP, HS_REQ, HS_REL} hs_e;

  localparam int SW = (SETUP_CYC > 0) ? $clog2(SETUP_CYC + 1) : 1;
  localparam logic [SW-1:0] SETUP_TOP = SW'(SETUP_CYC);

  hs_e             st_q;
  logic            out_q;
  logic [DB_W-1:0] byte_q;
  logic [SW-1:0]   scnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      out_q  <= 1'b0;
      byte_q <= '0;
      scnt_q <= '0;
    end else begin
      case (st_q)
        HS_IDLE: if (start_i) begin
          out_q  <= out_i;
          byte_q <= byte_i;
          scnt_q <= SW'(1);
          st_q   <= (out_i && SETUP_CYC > 0) ? HS_SETUP : HS_REQ;
        end
        HS_SETUP: begin
          if (scnt_q == SETUP_TOP) st_q <= HS_REQ;
          else                     scnt_q <= scnt_q + 1'b1;
        end
        HS_REQ: if (ack_i) begin
          if (!out_q) byte_q <= db_i;
          st_q <= HS_REL;
        end
        HS_REL: if (!ack_i) st_q <= HS_IDLE;
        default: st_q <= HS_IDLE;
      endcase
    end
  end

  assign req_o   = (st_q == HS_REQ);
  assign done_o  = (st_q == HS_REL) && !ack_i;
  assign idle_o  = (st_q == HS_IDLE);
  assign db_oe_o = out_q && (st_q != HS_IDLE);
  assign db_o    = byte_q;
  assign byte_o  = byte_q;

  // a request is withdrawn only after the acknowledge arrives
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> req_o);

  // no fresh request while the previous acknowledge is still up
  assert_no_req_in_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && ack_i) |=> !req_o);

  generate
    if (SETUP_CYC > 0) begin : g_setup_chk
      assert_data_before_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_o) && db_oe_o) |-> $past(db_oe_o));
    end
  endgenerate

endmodule

// File: rtl/tgt_phase_seq.sv
module tgt_phase_seq
  import tps_pkg::*;
#(
  parameter int DB_W       = 8,
  parameter int MY_ID      = 3,
  parameter int SETTLE_CYC = 4,
  parameter int SETUP_CYC  = 1,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             bsy_i,
  input  logic             bus_io_i,
  input  logic             ack_i,
  input  logic [DB_W-1:0]  db_i,
  output logic             bsy_o,
  output logic             cd_o,
  output logic             io_o,
  output logic             msg_o,
  output logic             req_o,
  output logic [DB_W-1:0]  db_o,
  output logic             db_oe_o,
  output logic [7:0]       cmd_byte_o,
  output logic             cmd_stb_o,
  input  logic [LEN_W-1:0] job_len_i,
  input  logic             job_din_i,
  input  logic [7:0]       job_status_i,
  input  logic [7:0]       msg_byte_i,
  output logic [LEN_W-1:0] xfer_idx_o,
  input  logic [7:0]       data_tx_i,
  output logic [7:0]       data_rx_o,
  output logic             data_rx_stb_o
);

  phase_e           ph_q;
  logic [LEN_W-1:0] idx_q, idx_nxt;
  logic [3:0]       cmd_len_q, grp_len;
  logic [LEN_W-1:0] len_q;
  logic             din_q;
  logic [7:0]       stat_q, msg_q;

  logic             sel_ok;
  logic             hs_start, hs_out, hs_done, hs_idle;
  logic [DB_W-1:0]  hs_tx, hs_rx;

  tps_sel_qual #(.DB_W(DB_W), .MY_ID(MY_ID), .SETTLE_CYC(SETTLE_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .bsy_i(bsy_i),
    .bus_io_i(bus_io_i), .db_i(db_i), .sel_ok_o(sel_ok)
  );

  assign hs_start = moves_bytes(ph_q) && hs_idle;
  assign hs_out   = target_sends(ph_q);

  always_comb begin
    case (ph_q)
      PH_DIN:  hs_tx = DB_W'(data_tx_i);
      PH_STAT: hs_tx = DB_W'(stat_q);
      PH_MSG:  hs_tx = DB_W'(msg_q);
      default: hs_tx = '0;
    endcase
  end

  tps_handshake #(.DB_W(DB_W), .SETUP_CYC(SETUP_CYC)) u_hs (
    .clk(clk), .rst_n(rst_n), .start_i(hs_start), .out_i(hs_out),
    .byte_i(hs_tx), .ack_i(ack_i), .db_i(db_i), .req_o(req_o),
    .db_o(db_o), .db_oe_o(db_oe_o), .byte_o(hs_rx), .done_o(hs_done),
    .idle_o(hs_idle)
  );

  assign idx_nxt = idx_q + 1'b1;
  assign grp_len = cdb_len(hs_rx[7:5]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_FREE;
      idx_q     <= '0;
      cmd_len_q <= '0;
      len_q     <= '0;
      din_q     <= 1'b0;
      stat_q    <= '0;
      msg_q     <= '0;
    end else begin
      case (ph_q)
        PH_FREE: if (sel_ok) ph_q <= PH_SELD;
        PH_SELD: if (!sel_i) begin
          ph_q  <= PH_CMD;
          idx_q <= '0;
        end
        PH_CMD: if (hs_done) begin
          if (idx_q == '0 && grp_len == 4'd0) begin
            stat_q <= STATUS_CHECK;
            msg_q  <= msg_byte_i;
            idx_q  <= '0;
            ph_q   <= PH_STAT;
          end else if (idx_q == '0) begin
            cmd_len_q <= grp_len;
            idx_q     <= idx_nxt;
          end else if (idx_nxt == LEN_W'(cmd_len_q)) begin
            len_q  <= job_len_i;
            din_q  <= job_din_i;
            stat_q <= job_status_i;
            msg_q  <= msg_byte_i;
            idx_q  <= '0;
            if (job_len_i == '0) ph_q <= PH_STAT;
            else if (job_din_i)  ph_q <= PH_DIN;
            else                 ph_q <= PH_DOUT;
          end else begin
            idx_q <= idx_nxt;
          end
        end
        PH_DIN, PH_DOUT: if (hs_done) begin
          if (idx_nxt == len_q) begin
            idx_q <= '0;
            ph_q  <= PH_STAT;
          end else begin
            idx_q <= idx_nxt;
          end
        end
        PH_STAT: if (hs_done) ph_q <= PH_MSG;
        PH_MSG:  if (hs_done) ph_q <= PH_FREE;
        default: ph_q <= PH_FREE;
      endcase
    end
  end

  assign bsy_o                = (ph_q != PH_FREE);
  assign {msg_o, cd_o, io_o}  = phase_lines(ph_q);
  assign xfer_idx_o           = idx_q;
  assign cmd_byte_o           = hs_rx[7:0];
  assign cmd_stb_o            = hs_done && (ph_q == PH_CMD);
  assign data_rx_o            = hs_rx[7:0];
  assign data_rx_stb_o        = hs_done && (ph_q == PH_DOUT);

  // busy rises only on a completed qualification
  assert_bsy_on_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_o) |-> $past(sel_ok));

  assert_req_needs_bsy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> bsy_o);

  assert_drive_needs_io_R11: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe_o |-> io_o);

  assert_lines_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> $stable({msg_o, cd_o, io_o}));

  // a single status byte hands over to the message phase
  assert_one_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_STAT && hs_done) |=> msg_o);

  assert_release_after_msg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bsy_o) |-> $past(msg_o));

  assert_cmd_in_cmd_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb_o |-> (cd_o && !io_o && !msg_o));

endmodule

// File: tb/tgt_phase_seq_bench.sv
module tgt_phase_seq_bench;

  localparam int DB_W   = 8;
  localparam int MY_ID  = 5;
  localparam int SETTLE = 3;
  localparam int SETUP  = 2;
  localparam int LEN_W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic sel_i = 0, bsy_i = 0, bus_io_i = 0, ack_i = 0;
  logic [DB_W-1:0] db_i = '0;
  logic bsy_o, cd_o, io_o, msg_o, req_o, db_oe_o, cmd_stb_o, data_rx_stb_o;
  logic [DB_W-1:0] db_o;
  logic [7:0] cmd_byte_o, data_rx_o, data_tx_i;
  logic [LEN_W-1:0] job_len_i = '0, xfer_idx_o;
  logic job_din_i = 0;
  logic [7:0] job_status_i = '0, msg_byte_i = '0;

  tgt_phase_seq #(.DB_W(DB_W), .MY_ID(MY_ID), .SETTLE_CYC(SETTLE),
                  .SETUP_CYC(SETUP), .LEN_W(LEN_W)) u_tgt_phase_seq (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .bsy_i(bsy_i), .bus_io_i(bus_io_i),
    .ack_i(ack_i), .db_i(db_i), .bsy_o(bsy_o), .cd_o(cd_o), .io_o(io_o),
    .msg_o(msg_o), .req_o(req_o), .db_o(db_o), .db_oe_o(db_oe_o),
    .cmd_byte_o(cmd_byte_o), .cmd_stb_o(cmd_stb_o), .job_len_i(job_len_i),
    .job_din_i(job_din_i), .job_status_i(job_status_i), .msg_byte_i(msg_byte_i),
    .xfer_idx_o(xfer_idx_o), .data_tx_i(data_tx_i), .data_rx_o(data_rx_o),
    .data_rx_stb_o(data_rx_stb_o)
  );

  int checks = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  function automatic int exp_cdb(input logic [7:0] b0);
    case (b0[7:5])
      3'd0: return 6;
      3'd1, 3'd2: return 10;
      3'd5: return 12;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] tx_pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] rx_pat(input int i);
    return 8'(((i * 13) & 255) ^ 8'h5a);
  endfunction

  assign data_tx_i = tx_pat(int'(xfer_idx_o));

  // upstream monitors
  logic [7:0] cmd_q [12];
  int cmd_seen = 0, rx_seen = 0;
  always @(negedge clk) begin
    if (rst_n && cmd_stb_o) begin
      chk(cmd_seen < 12 && cmd_byte_o == cmd_q[cmd_seen % 12], "R3 cmd byte",
          cmd_byte_o, cmd_q[cmd_seen % 12]);
      cmd_seen++;
    end
    if (rst_n && data_rx_stb_o) begin
      chk(data_rx_o == rx_pat(rx_seen), "R6 rx byte", data_rx_o, rx_pat(rx_seen));
      rx_seen++;
    end
  end

  // initiator side of one byte; returns after ack released
  task automatic do_ack(input string rq);
    int w, g;
    w = $urandom_range(0, 2);
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      chk(req_o == 1'b1, "R10 req held", req_o, 1);
    end
    ack_i = 1'b1;
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (req_o && g < 50);
    chk(!req_o, rq, req_o, 0);
    w = $urandom_range(0, 2);
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      chk(req_o == 1'b0, "R10 no req during ack", req_o, 0);
    end
    ack_i = 1'b0;
    db_i = '0;
  endtask

  task automatic select_me();
    @(negedge clk);
    sel_i = 1'b1;
    db_i = DB_W'(1) << MY_ID;
    repeat (SETTLE) @(negedge clk);
    chk(bsy_o == 1'b0, "R1 no busy before window", bsy_o, 0);
    @(negedge clk);
    chk(bsy_o == 1'b1, "R1 busy after window", bsy_o, 1);
    sel_i = 1'b0;
    db_i = '0;
  endtask

  task automatic run_session(input logic [7:0] b0, input int len, input bit din,
                             input logic [7:0] st, input logic [7:0] mb);
    int ncmd, elen, n_cmd, n_din, n_dout, n_st, n_msg, guard;
    logic [7:0] est, st_val, msg_val;
    logic [2:0] ph;
    bit prev_oe;
    cmd_q[0] = b0;
    for (int i = 1; i < 12; i++) cmd_q[i] = 8'($urandom_range(0, 255));
    ncmd = (exp_cdb(b0) == 0) ? 1 : exp_cdb(b0);
    elen = (exp_cdb(b0) == 0) ? 0 : len;
    est  = (exp_cdb(b0) == 0) ? 8'h02 : st;
    job_len_i = LEN_W'(len);
    job_din_i = din;
    job_status_i = st;
    msg_byte_i = mb;
    cmd_seen = 0; rx_seen = 0;
    n_cmd = 0; n_din = 0; n_dout = 0; n_st = 0; n_msg = 0;
    st_val = 0; msg_val = 0; prev_oe = 0; guard = 0;
    select_me();
    while (bsy_o && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (req_o) begin
        ph = {msg_o, cd_o, io_o};
        if (!io_o) begin
          if (cd_o) begin
            chk(ph == 3'b010, "R2 command lines", ph, 3'b010);
            db_i = cmd_q[n_cmd % 12];
            n_cmd++;
          end else begin
            chk(ph == 3'b000, "R6 data-out lines", ph, 3'b000);
            db_i = rx_pat(n_dout);
            n_dout++;
          end
          do_ack("R10 req drops on ack");
        end else begin
          chk(db_oe_o && prev_oe, "R10 data before req", {prev_oe, db_oe_o}, 2'b11);
          case (ph)
            3'b001: begin
              chk(db_o == tx_pat(n_din), "R5 data-in byte", db_o, tx_pat(n_din));
              n_din++;
            end
            3'b011: begin st_val = db_o; n_st++; end
            3'b111: begin msg_val = db_o; n_msg++; end
            default: chk(0, "R5 phase code", ph, 3'b001);
          endcase
          do_ack("R10 req drops on ack");
        end
        prev_oe = 0;
      end else begin
        if (db_oe_o) chk(io_o, "R11 drive only in io", io_o, 1);
        prev_oe = db_oe_o;
      end
    end
    chk(guard < 5000, "R9 session ends", guard, 0);
    @(negedge clk);
    chk({bsy_o, msg_o, cd_o, io_o} == 4'b0, "R9 bus free", {bsy_o, msg_o, cd_o, io_o}, 0);
    chk(n_cmd == ncmd, (ncmd == 1) ? "R4 cmd count" : "R3 cmd count", n_cmd, ncmd);
    chk(cmd_seen == ncmd, "R3 cmd strobes", cmd_seen, ncmd);
    if (elen == 0)
      chk(n_din + n_dout == 0, (ncmd == 1) ? "R4 data skipped" : "R7 data skipped",
          n_din + n_dout, 0);
    else if (din)
      chk(n_din == elen && n_dout == 0, "R5 data-in count", n_din, elen);
    else
      chk(n_dout == elen && rx_seen == elen && n_din == 0, "R6 data-out count",
          n_dout, elen);
    chk(n_st == 1, "R8 one status", n_st, 1);
    chk(st_val == est, (ncmd == 1) ? "R4 check status" : "R8 status value", st_val, est);
    chk(n_msg == 1, "R9 one message", n_msg, 1);
    chk(msg_val == mb, "R9 message value", msg_val, mb);
  endtask

  task automatic hold_cond(input logic s, input logic [DB_W-1:0] d, input logic b,
                           input logic io, input int n, input string rq);
    @(negedge clk);
    sel_i = s; db_i = d; bsy_i = b; bus_io_i = io;
    repeat (n) @(negedge clk);
    chk(bsy_o == 1'b0, rq, bsy_o, 0);
    sel_i = 0; db_i = '0; bsy_i = 0; bus_io_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    logic [7:0] own;
    void'($urandom(32'd4242));
    own = DB_W'(1) << MY_ID;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bsy_o, req_o, cd_o, io_o, msg_o, db_oe_o} == 6'b0, "R11 reset idle",
        {bsy_o, req_o, cd_o, io_o, msg_o, db_oe_o}, 0);

    // R1 blocking conditions
    hold_cond(1, DB_W'(1) << (MY_ID ^ 1), 0, 0, 10, "R1 other id ignored");
    hold_cond(1, own, 1, 0, 10, "R1 external busy blocks");
    hold_cond(1, own, 0, 1, 10, "R1 io blocks");
    // R1 break on the last cycle of the window restarts the count
    @(negedge clk);
    sel_i = 1; db_i = own;
    repeat (SETTLE) @(negedge clk);
    sel_i = 0;
    @(negedge clk);
    chk(bsy_o == 1'b0, "R1 break restarts", bsy_o, 0);
    sel_i = 1;
    repeat (SETTLE) @(negedge clk);
    chk(bsy_o == 1'b0, "R1 full window again", bsy_o, 0);
    sel_i = 0; db_i = '0;
    repeat (3) @(negedge clk);
    chk(bsy_o == 1'b0, "R1 no late busy", bsy_o, 0);

    // directed sessions
    run_session(8'h00, 0, 1, 8'h00, 8'h00);   // R7
    run_session(8'h28, 5, 1, 8'h08, 8'h00);   // group 1 data-in
    run_session(8'h4a, 3, 0, 8'h00, 8'h00);   // group 2 data-out
    run_session(8'ha0, 1, 1, 8'h18, 8'h00);   // group 5 single byte
    run_session(8'h61, 4, 1, 8'h00, 8'h00);   // group 3 R4
    run_session(8'hff, 7, 0, 8'h00, 8'h00);   // group 7 R4
    run_session(8'h03, 63, 0, 8'h00, 8'h00);  // largest transfer

    // random sessions
    for (int s = 0; s < 10; s++) begin
      logic [7:0] b0;
      b0 = 8'($urandom_range(0, 255));
      run_session(b0, $urandom_range(0, 20), 1'($urandom_range(0, 1)),
                  8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)));
    end

    repeat (5) @(negedge clk);
    wrap_up();
  end

endmodule